// File: doc/BRIEF.md
# Multicycle Issue Hazard Checker

This block sits beside the decode stage of a pipeline that feeds several execution units of different lengths: a one-stage integer unit (also used for loads), a four-stage pipelined adder, a seven-stage pipelined multiplier, and an unpipelined divider that spends twenty-five cycles per operation. In every cycle it looks at the decoded instruction waiting in decode and decides whether the instruction may leave for its unit or must wait.

An instruction is held back for any of four reasons. The divider may still be busy. The single register write port may already be claimed for the cycle in which the instruction would write back. A source register may still be waiting for an older result. An older write to the same destination may still be in flight and land at the same time as the new one or later. All four checks are evaluated together, and any one of them stalls the instruction. A stalled instruction leaves no record behind, so the execute stages receive a bubble. Each issued write is tracked by the number of cycles left until its write-back.

Top module: `mfp_issue_chk`

## Requirements
- R1: When `id_valid` is high, exactly one of `issue` and `stall` is high. When it is low, both are low and `cause` is zero.
- R2: Unit codes are 0 integer, 1 load, 2 add, 3 multiply, 4 divide; codes 5 to 7 act as integer. An instruction issued in cycle t writes back in cycle t+3 (integer, load), t+6 (add), t+9 (multiply) or t+27 (divide).
- R3: The instruction stalls with a port cause if it writes a register and its write-back cycle equals that of a write already in flight.
- R4: The instruction stalls with a data cause if a nonzero source matches the destination of an in-flight write whose result is not yet usable. A result from cycle t is usable by an instruction issuing in cycle t+1 (integer), t+2 (load), t+4 (add), t+7 (multiply) or t+25 (divide), and in any later cycle.
- R5: The instruction stalls with an order cause if an in-flight write to the same nonzero destination would write back in the same cycle as the new instruction or later.
- R6: After a divide issues in cycle t, any divide presented in cycles t+1 to t+24 stalls with a divider cause. A divide can issue again from cycle t+25.
- R7: Register 0 means "no register". A zero source raises no data hazard. A zero destination reserves no write cycle and raises no port or order hazard.
- R8: A stalled instruction records nothing. Later instructions see no reservation, dependency or divider use from it.
- R9: `cause` bit 3 is divider, bit 2 is port, bit 1 is data, bit 0 is order. Every hazard present is flagged at once, and `stall` is the OR of the bits.
- R10: Reset clears every in-flight record and frees the divider.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_valid | input | 1 | Decode holds an instruction |
| id_unit | input | 3 | Unit code of the instruction |
| id_src_a | input | RW | First source register, 0 for none |
| id_src_b | input | RW | Second source register, 0 for none |
| id_dst | input | RW | Destination register, 0 for none |
| issue | output | 1 | Instruction leaves decode this cycle |
| stall | output | 1 | Instruction is held in decode |
| cause | output | 4 | Hazard flags: divider, port, data, order |

## Verification
A scripted stream mixes all five unit kinds, so that each hazard appears both alone and with another one. Producer-consumer pairs at exactly the usable distance and one cycle short of it separate the load-use bubble from the longer floating-point waits. Integer writes aimed at a multiplier's or adder's write-back cycle show whether the write-back distances are right, and a write to a register with a long divide pending separates order hazards from port hazards. Directed steps then probe the last busy cycle of the divider, zero registers, and the removal of all records by reset.

// File: rtl/mfp_pkg.sv
package mfp_pkg;
  typedef enum logic [2:0] {
    U_INT  = 3'd0,
    U_LOAD = 3'd1,
    U_FADD = 3'd2,
    U_FMUL = 3'd3,
    U_FDIV = 3'd4
  } unit_e;

  localparam int CZ_DIV  = 3;
  localparam int CZ_PORT = 2;
  localparam int CZ_RAW  = 1;
  localparam int CZ_WAW  = 0;
endpackage

// File: rtl/mfp_wb_table.sv
module mfp_wb_table #(
  parameter int DEPTH = 28,
  parameter int RW    = 5,
  parameter int IW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ins_en,
  input  logic [IW-1:0] ins_idx,
  input  logic [RW-1:0] ins_dst,
  input  logic [IW-1:0] ins_rdy,
  output logic          occ   [DEPTH],
  output logic [RW-1:0] s_dst [DEPTH],
  output logic [IW-1:0] s_rdy [DEPTH]
);
  // slot k holds the write that lands k cycles from now; all slots advance each cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) begin
        occ[k]   <= 1'b0;
        s_dst[k] <= '0;
        s_rdy[k] <= '0;
      end
    end else begin
      for (int k = 0; k < DEPTH - 1; k++) begin
        occ[k]   <= occ[k+1];
        s_dst[k] <= s_dst[k+1];
        s_rdy[k] <= s_rdy[k+1];
      end
      occ[DEPTH-1]   <= 1'b0;
      s_dst[DEPTH-1] <= '0;
      s_rdy[DEPTH-1] <= '0;
      if (ins_en) begin
        occ[ins_idx]   <= 1'b1;
        s_dst[ins_idx] <= ins_dst;
        s_rdy[ins_idx] <= ins_rdy;
      end
    end
  end

  // R3: a new write never lands on a write-back cycle that is already claimed
  assert_port_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ins_en |-> !occ[ins_idx + IW'(1)]);
endmodule

// File: rtl/mfp_div_busy.sv
module mfp_div_busy #(
  parameter int II = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(II + 1);
  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n)           remain <= '0;
    else if (start)       remain <= CW'(II - 1);
    else if (remain != 0) remain <= remain - CW'(1);
  end

  assign busy = (remain != '0);

  assert_div_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);

  generate
    if (II > 1) begin : g_hold
      assert_div_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
    end
  endgenerate
endmodule

// File: rtl/mfp_issue_chk.sv
module mfp_issue_chk
  import mfp_pkg::*;
#(
  parameter int RW       = 5,
  parameter int ADD_ST   = 4,
  parameter int MUL_ST   = 7,
  parameter int DIV_ST   = 25,
  parameter int LOAD_LAT = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          id_valid,
  input  logic [2:0]    id_unit,
  input  logic [RW-1:0] id_src_a,
  input  logic [RW-1:0] id_src_b,
  input  logic [RW-1:0] id_dst,
  output logic          issue,
  output logic          stall,
  output logic [3:0]    cause
);
  localparam int DEPTH = DIV_ST + 3;
  localparam int IW    = $clog2(DEPTH + 1);

  // execute stages occupied by a unit
  function automatic int f_stages(logic [2:0] u);
    case (u)
      U_FADD:  return ADD_ST;
      U_FMUL:  return MUL_ST;
      U_FDIV:  return DIV_ST;
      default: return 1;
    endcase
  endfunction

  // extra cycles before a result can be forwarded
  function automatic int f_lat(logic [2:0] u);
    case (u)
      U_LOAD:  return LOAD_LAT;
      U_FADD:  return ADD_ST - 1;
      U_FMUL:  return MUL_ST - 1;
      U_FDIV:  return DIV_ST - 1;
      default: return 0;
    endcase
  endfunction

  // cycles from issue to write-back: stages, then memory, then write-back
  function automatic int f_wb_dist(logic [2:0] u);
    return f_stages(u) + 2;
  endfunction

  // remaining distance to write-back at or below which the result is usable
  function automatic int f_rdy_dist(logic [2:0] u);
    return f_stages(u) + 1 - f_lat(u);
  endfunction

  logic [IW-1:0] wb_dist, rdy_dist;
  assign wb_dist  = IW'(f_wb_dist(id_unit));
  assign rdy_dist = IW'(f_rdy_dist(id_unit));

  logic          occ   [DEPTH];
  logic [RW-1:0] s_dst [DEPTH];
  logic [IW-1:0] s_rdy [DEPTH];
  logic          ins_en, div_start, div_busy, has_dst;
  logic [IW-1:0] ins_idx;
  logic [DEPTH-1:0] hit_raw, hit_waw, hit_port;
  logic [3:0]    cause_raw;

  assign has_dst = (id_dst != '0);

  generate
    for (genvar k = 0; k < DEPTH; k++) begin : g_cmp
      localparam logic [IW-1:0] KV = IW'(k);
      assign hit_raw[k]  = occ[k] && (KV > s_rdy[k]) &&
                           ((id_src_a != '0 && id_src_a == s_dst[k]) ||
                            (id_src_b != '0 && id_src_b == s_dst[k]));
      assign hit_waw[k]  = occ[k] && has_dst && (id_dst == s_dst[k]) && (KV >= wb_dist);
      assign hit_port[k] = occ[k] && has_dst && (KV == wb_dist);
    end
  endgenerate

  always_comb begin
    cause_raw          = '0;
    cause_raw[CZ_DIV]  = div_busy && (id_unit == U_FDIV);
    cause_raw[CZ_PORT] = |hit_port;
    cause_raw[CZ_RAW]  = |hit_raw;
    cause_raw[CZ_WAW]  = |hit_waw;
  end

  assign cause     = id_valid ? cause_raw : 4'b0000;
  assign stall     = |cause;
  assign issue     = id_valid && (cause_raw == 4'b0000);
  assign ins_en    = issue && has_dst;
  assign ins_idx   = wb_dist - IW'(1);
  assign div_start = issue && (id_unit == U_FDIV);

  mfp_wb_table #(.DEPTH(DEPTH), .RW(RW), .IW(IW)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .ins_en  (ins_en),
    .ins_idx (ins_idx),
    .ins_dst (id_dst),
    .ins_rdy (rdy_dist),
    .occ     (occ),
    .s_dst   (s_dst),
    .s_rdy   (s_rdy)
  );

  mfp_div_busy #(.II(DIV_ST)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .start (div_start),
    .busy  (div_busy)
  );

  assert_one_outcome_R1: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid |-> (issue ^ stall));
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !id_valid |-> (!issue && !stall && cause == 4'b0000));
  assert_zero_dst_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && id_dst == '0) |-> !cause[CZ_PORT] && !cause[CZ_WAW]);
endmodule

// File: tb/test_mfp_issue_chk.sv
`timescale 1ns/1ps
module test_mfp_issue_chk;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       id_valid = 1'b0;
  logic [2:0] id_unit = 3'd0;
  logic [4:0] id_src_a = '0, id_src_b = '0, id_dst = '0;
  logic       issue, stall;
  logic [3:0] cause;

  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mfp_issue_chk i_mfp_issue_chk (
    .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_unit(id_unit),
    .id_src_a(id_src_a), .id_src_b(id_src_b), .id_dst(id_dst),
    .issue(issue), .stall(stall), .cause(cause)
  );

  // unit, dst, src_a, src_b, valid, expected issue, expected cause {div,port,data,order}
  localparam logic [23:0] VEC [0:20] = '{
    {3'd3, 5'd1,  5'd2,  5'd3,  1'b1, 1'b1, 4'b0000}, // c0 mul f1, write-back c9
    {3'd2, 5'd4,  5'd1,  5'd5,  1'b1, 1'b0, 4'b0010}, // c1 R4 waits on mul
    {3'd2, 5'd6,  5'd7,  5'd8,  1'b1, 1'b1, 4'b0000}, // c2 add f6, write-back c8
    {3'd0, 5'd9,  5'd10, 5'd11, 1'b1, 1'b1, 4'b0000}, // c3 int, write-back c6
    {3'd0, 5'd12, 5'd6,  5'd0,  1'b1, 1'b0, 4'b0010}, // c4 R4 add not ready
    {3'd0, 5'd13, 5'd0,  5'd0,  1'b1, 1'b0, 4'b0100}, // c5 R2/R3 hits add slot c8
    {3'd0, 5'd1,  5'd2,  5'd0,  1'b1, 1'b0, 4'b0101}, // c6 R9 port and order together
    {3'd2, 5'd14, 5'd1,  5'd0,  1'b1, 1'b1, 4'b0000}, // c7 R4 mul result just usable
    {3'd4, 5'd20, 5'd21, 5'd22, 1'b1, 1'b1, 4'b0000}, // c8 div f20, write-back c35
    {3'd4, 5'd23, 5'd21, 5'd22, 1'b1, 1'b0, 4'b1000}, // c9 R6 divider busy
    {3'd1, 5'd24, 5'd1,  5'd0,  1'b1, 1'b0, 4'b0100}, // c10 R3 load hits c13
    {3'd1, 5'd24, 5'd1,  5'd0,  1'b1, 1'b1, 4'b0000}, // c11 load f24
    {3'd0, 5'd25, 5'd24, 5'd0,  1'b1, 1'b0, 4'b0010}, // c12 R4 load-use bubble
    {3'd0, 5'd25, 5'd24, 5'd0,  1'b1, 1'b1, 4'b0000}, // c13 R4 load now usable
    {3'd0, 5'd26, 5'd20, 5'd0,  1'b1, 1'b0, 4'b0010}, // c14 R4 divide not ready
    {3'd2, 5'd20, 5'd1,  5'd2,  1'b1, 1'b0, 4'b0001}, // c15 R5 order; R8 stalled c6 left no f1
    {3'd0, 5'd0,  5'd0,  5'd0,  1'b0, 1'b0, 4'b0000}, // c16 R1 empty decode
    {3'd2, 5'd0,  5'd3,  5'd0,  1'b1, 1'b1, 4'b0000}, // c17 R7 add to r0 reserves nothing
    {3'd3, 5'd29, 5'd30, 5'd0,  1'b1, 1'b1, 4'b0000}, // c18 mul f29, write-back c27
    {3'd0, 5'd30, 5'd29, 5'd0,  1'b1, 1'b0, 4'b0010}, // c19 R4 mul not ready
    {3'd0, 5'd28, 5'd0,  5'd0,  1'b1, 1'b1, 4'b0000}  // c20 R7 slot c23 free
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic v, input logic [2:0] u, input logic [4:0] d,
                       input logic [4:0] a, input logic [4:0] b);
    id_valid = v; id_unit = u; id_dst = d; id_src_a = a; id_src_b = b;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    string tg;
    logic [3:0] ec;
    drive(1'b0, 3'd0, 5'd0, 5'd0, 5'd0);
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset idle issue", {31'd0, issue}, 32'd0);
    chk("R1 reset idle stall", {31'd0, stall}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < 21; i++) begin
      if (i > 0) @(negedge clk);
      drive(VEC[i][5], VEC[i][23:21], VEC[i][20:16], VEC[i][15:11], VEC[i][10:6]);
      #1;
      ec = VEC[i][3:0];
      if (ec[3])      tg = "R6";
      else if (ec[2]) tg = "R3";
      else if (ec[1]) tg = "R4";
      else if (ec[0]) tg = "R5";
      else if (!VEC[i][5]) tg = "R1";
      else tg = "R2";
      chk($sformatf("%s issue c%0d", tg, i), {31'd0, issue}, {31'd0, VEC[i][4]});
      chk($sformatf("R1 stall c%0d", i), {31'd0, stall}, {31'd0, VEC[i][5] & ~VEC[i][4]});
      chk($sformatf("R9 cause c%0d", i), {28'd0, cause}, {28'd0, ec});
    end

    // idle c21..c31
    for (int c = 21; c < 32; c++) begin
      @(negedge clk);
      drive(1'b0, 3'd0, 5'd0, 5'd0, 5'd0);
    end
    // c32: last busy cycle of the divider issued at c8
    @(negedge clk);
    drive(1'b1, 3'd4, 5'd31, 5'd1, 5'd0);
    #1;
    chk("R6 divide at t+24 stalls", {28'd0, cause}, 32'h8);
    // c33: divider free again
    @(negedge clk);
    #1;
    chk("R6 divide at t+25 issues", {31'd0, issue}, 32'd1);
    // c34: divider busy with the new divide
    @(negedge clk);
    drive(1'b1, 3'd4, 5'd2, 5'd3, 5'd0);
    #1;
    chk("R6 divide after divide stalls", {31'd0, stall}, 32'd1);

    // reset with divide f31 in flight
    @(negedge clk);
    drive(1'b0, 3'd0, 5'd0, 5'd0, 5'd0);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    drive(1'b1, 3'd0, 5'd31, 5'd31, 5'd0);
    #1;
    chk("R10 no record of f31 after reset", {28'd0, cause}, 32'h0);
    chk("R10 int issues after reset", {31'd0, issue}, 32'd1);
    @(negedge clk);
    drive(1'b1, 3'd4, 5'd5, 5'd6, 5'd0);
    #1;
    chk("R10 divider free after reset", {31'd0, issue}, 32'd1);
    // unit code 7 acts as integer: write-back t+3 hits int slot from previous cycle+... check r7 path
    @(negedge clk);
    drive(1'b1, 3'd7, 5'd7, 5'd5, 5'd0);
    #1;
    chk("R4 code 7 waits on divide f5", {28'd0, cause}, 32'h2);
    @(negedge clk);
    drive(1'b0, 3'd0, 5'd0, 5'd0, 5'd0);
    #1;
    chk("R1 idle after stream", {31'd0, issue | stall}, 32'd0);

    finish_run();
  end
endmodule